// File: doc/BRIEF.md
# Loadable Counter with Staging Register

This block is a binary up-counter whose parallel load value comes from a separate staging register. Both share one set of bidirectional data pins, modelled here as a pin-input bus, a pin-output bus and a pin-drive enable. When the pins are released they act as inputs, and a register strobe samples them into the staging register. The counter can be cleared, loaded from the staging register, or advanced on a counter strobe. When the pins are driven they present the running count.

Everything runs on one system clock. The two strobes stand in for the separate register and counter clocks, and each lasts one system cycle. An active-low carry output marks the all-ones count. Feeding that carry into the active-low count enable of a second instance builds a two-stage chain that shares one counter strobe.

Top module: `staged_load_counter`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) sets the count and the staging register to zero. After reset, carry_n is high and pin_oe is low as long as the output enables are inactive.
- R2: A clock edge with reg_stb high stores pin_in into the staging register. Without reg_stb the staging register keeps its value, and this is observed through a later load.
- R3: clr_n low at a clock edge sets the count to zero. This overrides load_n, the strobes and the count enables.
- R4: With clr_n high, load_n low at a clock edge copies the staging register into the count, whatever the counter strobe and enables are. If reg_stb is high in the same cycle, the count receives the value the register held before that edge.
- R5: With clr_n and load_n high, the count rises by one at a clock edge only when cnt_stb is high, cnt_en_n is low and cnt_en is high. Any other combination holds the count.
- R6: Incrementing from the all-ones value gives zero.
- R7: carry_n is low exactly while the count is all ones.
- R8: pin_oe is high only when out_en_n is low and out_en is high. pin_out carries the count at all times.
- R9: In a chain where carry_n of a first stage drives cnt_en_n of a second stage, and both stages share cnt_stb, the second stage advances once each time the first stage wraps through all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_stb | input | 1 | One-cycle strobe that stands in for the register clock |
| cnt_stb | input | 1 | One-cycle strobe that stands in for the counter clock |
| clr_n | input | 1 | Active-low clear |
| load_n | input | 1 | Active-low load from the staging register |
| cnt_en_n | input | 1 | Active-low count enable |
| cnt_en | input | 1 | Active-high count enable |
| out_en_n | input | 1 | Active-low output enable |
| out_en | input | 1 | Active-high output enable |
| pin_in | input | WIDTH | Value sampled from the shared pins |
| pin_out | output | WIDTH | Count value offered to the shared pins |
| pin_oe | output | 1 | High when the shared pins are driven |
| carry_n | output | 1 | Active-low terminal-count flag |

## Verification
The count is driven through all four settings of the two enables, with the counter strobe both present and absent. This separates a correct AND of the enables from a wrong polarity or a missing strobe term. Clear and load are applied together, and load is applied together with counting and with a same-cycle register capture. These cases show the priority order and whether the load takes the old register value or the new one. A load of FC followed by four counts across the wrap checks the carry pulse and the return to zero. A cascaded second instance, run through more than 256 first-stage counts, shows that the carry is correctly used as an enable.

// File: rtl/slc_pkg.sv
package slc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic step;
    } cnt_req_t;

    function automatic logic pair_on(input logic act_lo, input logic act_hi);
        return (!act_lo) && act_hi;
    endfunction

    function automatic cnt_op_e pick_op(input cnt_req_t r);
        if (r.clr)       return OP_CLEAR;
        else if (r.load) return OP_LOAD;
        else if (r.step) return OP_INC;
        else             return OP_HOLD;
    endfunction

endpackage

// File: rtl/slc_stage_reg.sv
module slc_stage_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (cap) q <= d;
    end

    AST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        cap |=> q == $past(d)); // R2
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q)); // R2
endmodule

// File: rtl/slc_ctrl_decode.sv
module slc_ctrl_decode (
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_stb,
    input  logic             cnt_en_n,
    input  logic             cnt_en,
    input  logic             out_en_n,
    input  logic             out_en,
    output slc_pkg::cnt_op_e op,
    output logic             drive
);
    import slc_pkg::*;
    cnt_req_t req;

    always_comb begin
        req.clr  = !clr_n;
        req.load = !load_n;
        req.step = cnt_stb && pair_on(cnt_en_n, cnt_en);
        op       = pick_op(req);
        drive    = pair_on(out_en_n, out_en);
    end
endmodule

// File: rtl/slc_counter_core.sv
module slc_counter_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  slc_pkg::cnt_op_e op,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             term_n
);
    import slc_pkg::*;
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = load_val;
            OP_INC:   nxt = count + 1'b1;
            default:  nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

    assign term_n = (count != TOP);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        op == OP_CLEAR |=> count == '0); // R3
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> count == $past(load_val)); // R4
    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC && $past(op) != OP_HOLD) |=> count == WIDTH'($past(count) + 1'b1)); // R5
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(count)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC && !term_n) |=> count == '0); // R6
endmodule

// File: rtl/staged_load_counter.sv
module staged_load_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_stb,
    input  logic             cnt_stb,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             cnt_en,
    input  logic             out_en_n,
    input  logic             out_en,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_oe,
    output logic             carry_n
);
    import slc_pkg::*;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] count_q;
    cnt_op_e          op;

    slc_stage_reg #(.WIDTH(WIDTH)) stage_i (
        .clk(clk), .rst(rst), .cap(reg_stb), .d(pin_in), .q(stage_q)
    );

    slc_ctrl_decode decode_i (
        .clr_n(clr_n), .load_n(load_n), .cnt_stb(cnt_stb),
        .cnt_en_n(cnt_en_n), .cnt_en(cnt_en),
        .out_en_n(out_en_n), .out_en(out_en),
        .op(op), .drive(pin_oe)
    );

    slc_counter_core #(.WIDTH(WIDTH)) core_i (
        .clk(clk), .rst(rst), .op(op), .load_val(stage_q),
        .count(count_q), .term_n(carry_n)
    );

    assign pin_out = count_q;

    AST_CLEAR_PORT: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> pin_out == '0); // R3
    AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (rst)
        (out_en_n || !out_en) |-> !pin_oe); // R8
    AST_CARRY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> carry_n); // R7
endmodule

// File: tb/staged_load_counter_tb_top.sv
`timescale 1ns/1ps
module staged_load_counter_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_stb = 0, cnt_stb = 0, clr_n = 1, load_n = 1;
    logic cnt_en_n = 0, cnt_en = 1, out_en_n = 1, out_en = 0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_out2;
    logic pin_oe, carry_n, pin_oe2, carry_n2;

    always #2.5 clk = ~clk;

    staged_load_counter #(.WIDTH(8)) dut_i (
        .clk(clk), .rst(rst), .reg_stb(reg_stb), .cnt_stb(cnt_stb),
        .clr_n(clr_n), .load_n(load_n), .cnt_en_n(cnt_en_n), .cnt_en(cnt_en),
        .out_en_n(out_en_n), .out_en(out_en), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .carry_n(carry_n)
    );

    staged_load_counter #(.WIDTH(8)) dut2_i (
        .clk(clk), .rst(rst), .reg_stb(1'b0), .cnt_stb(cnt_stb),
        .clr_n(clr_n), .load_n(1'b1), .cnt_en_n(carry_n), .cnt_en(1'b1),
        .out_en_n(out_en_n), .out_en(out_en), .pin_in(8'h00),
        .pin_out(pin_out2), .pin_oe(pin_oe2), .carry_n(carry_n2)
    );

    int checks = 0, errors = 0;
    int ref_cnt = 0, ref_stage = 0, ref_cnt2 = 0;
    string tag = "R1";
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model update for one rising edge
    task automatic model_edge();
        int c1_top;
        c1_top = (ref_cnt == 255);
        if (rst) begin
            ref_cnt = 0; ref_stage = 0; ref_cnt2 = 0;
        end else begin
            if (!clr_n) begin
                ref_cnt = 0; ref_cnt2 = 0;
            end else begin
                if (!load_n) ref_cnt = ref_stage;
                else if (cnt_stb && !cnt_en_n && cnt_en) ref_cnt = (ref_cnt + 1) % 256;
                if (cnt_stb && c1_top) ref_cnt2 = (ref_cnt2 + 1) % 256;
            end
            if (reg_stb) ref_stage = pin_in;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, pin_out, ref_cnt);
        chk("R7", carry_n, (ref_cnt == 255) ? 0 : 1);
        chk("R8", pin_oe, (!out_en_n && out_en) ? 1 : 0);
        chk("R9", pin_out2, ref_cnt2);
    endtask

    task automatic idle();
        reg_stb = 0; cnt_stb = 0; clr_n = 1; load_n = 1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset
        tag = "R1";
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        cyc();
        chk("R1", carry_n, 1);
        chk("R1", pin_oe, 0);

        // R2 capture, R4 load
        tag = "R2";
        pin_in = 8'hFC; reg_stb = 1; cyc();
        reg_stb = 0; pin_in = 8'h33; load_n = 0; tag = "R4"; cyc();
        chk("R4", pin_out, 8'hFC);
        idle(); cnt_stb = 1; cyc(); idle();
        load_n = 0; tag = "R2"; cyc();
        chk("R2", pin_out, 8'hFC);

        // R4 same-cycle capture loads old value
        idle(); pin_in = 8'h5A; reg_stb = 1; load_n = 0; tag = "R4"; cyc();
        chk("R4", pin_out, 8'hFC);
        reg_stb = 0; cyc();
        chk("R4", pin_out, 8'h5A);
        // load overrides counting
        cnt_stb = 1; cyc();
        chk("R4", pin_out, 8'h5A);

        // R3 clear beats load and count
        clr_n = 0; tag = "R3"; cyc();
        chk("R3", pin_out, 0);

        // R5 enable combinations
        idle(); tag = "R5";
        for (int k = 0; k < 4; k++) begin
            cnt_en_n = k[0]; cnt_en = k[1];
            cnt_stb = 1; cyc(); cyc();
            cnt_stb = 0; cyc();
        end
        chk("R5", pin_out, 2);
        cnt_en_n = 0; cnt_en = 1;

        // R6/R7 FC to 00 with carry pulse
        idle(); pin_in = 8'hFC; reg_stb = 1; cyc();
        reg_stb = 0; load_n = 0; cyc(); load_n = 1;
        tag = "R6"; cnt_stb = 1;
        cyc(); cyc(); cyc();
        chk("R7", carry_n, 0);
        cyc();
        chk("R6", pin_out, 0);
        chk("R7", carry_n, 1);

        // R8 output enable combinations
        idle(); tag = "R8";
        for (int k = 0; k < 4; k++) begin
            out_en_n = k[0]; out_en = k[1]; cyc();
        end
        out_en_n = 0; out_en = 1; cyc();
        chk("R8", pin_oe, 1);

        // R9 cascade
        clr_n = 0; cyc(); idle(); tag = "R9"; cnt_stb = 1;
        for (int k = 0; k < 600; k++) begin
            if (k % 7 == 3) cnt_stb = 0; else cnt_stb = 1;
            cyc();
        end
        chk("R9", pin_out2, ref_cnt2);
        chk("R9", (ref_cnt2 >= 2) ? 1 : 0, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule